// File: doc/BRIEF.md
# SDRAM Bank Write Sequencer

This block turns write requests from a user port into a legal command stream for a synchronous DRAM with four banks. Each request carries a bank, a row, a column start, an auto-precharge flag and a whole burst of data. The block opens the row when it must, precharging first if a different row is open in that bank. It then issues the write command and drives the burst onto the data bus, starting in the same cycle as the write command.

Every bank has its own timers for activate-to-write delay, minimum row-active time, write recovery and precharge. A command goes out in the first cycle those timers allow it. After a write with auto-precharge the bank closes by itself. It accepts no command until its internal precharge has run. That precharge begins write-recovery cycles after the last datum, or when the minimum row-active time ends, whichever is later. The user port is a valid/ready handshake. Ready is low while a request is being worked on, including any wait on a bank that is locked.

Top module: `sdw_write_ctrl`

## Requirements
- R1: While reset is held and right after it, req_ready_o is 1, cmd_o is NOP and dq_oe_o is 0.
- R2: cmd_o is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, ACT = 0011, WRITE = 0100, PRE = 0010. ba_o carries the bank. With ACT, addr_o carries the row. With WRITE, addr_o[8:0] carries the column and addr_o[10] carries the auto-precharge flag. With PRE, addr_o[10] is 0.
- R3: A WRITE goes only to an open bank, no earlier than TRCD cycles after its ACT. When a request opened the row itself, its WRITE follows the ACT by exactly TRCD cycles.
- R4: The first datum is on dq_o in the WRITE cycle. The remaining BL-1 data follow on consecutive cycles. dq_oe_o is high for exactly those BL cycles.
- R5: Word j of req_data_i (bits j*16 +: 16) belongs to column base+j of the BL-aligned block. Let s be the column start modulo BL. In beat i the block sends word (s+i) mod BL when the burst type is sequential, and word s XOR i when it is interleaved.
- R6: A PRE to a bank comes no earlier than TRAS cycles after its ACT. It also comes no earlier than TWR cycles after the last datum of the latest write to that bank.
- R7: An ACT goes only to a closed bank, no earlier than TRP cycles after the bank's precharge. When a request issues PRE then ACT, the two are exactly TRP cycles apart.
- R8: A request to the open row goes straight to WRITE. A request to a closed bank issues ACT first. A request to another row of an open bank issues PRE, then ACT.
- R9: After a WRITE with addr_o[10]=1, no command reaches that bank until the internal precharge has completed. A waiting request to that bank gets its ACT exactly BL+TWR-1+TRP cycles after the WRITE, provided the minimum row-active time is not the later limit.
- R10: A request is taken on a cycle where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after that until the last beat of the burst.
- R11: In any cycle where no command is due, cmd_o is NOP, including while idle and during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_bank_i | input | 2 | Target bank |
| req_row_i | input | 13 | Target row |
| req_col_i | input | 9 | Column start |
| req_ap_i | input | 1 | Auto-precharge after the write |
| req_data_i | input | 64 | Burst data, word j for column base+j |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Row, or column plus auto-precharge bit |
| dq_o | output | 16 | Write data |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench goes after the exact spacing of ACT to WRITE and of PRE to ACT. A design that added a slack cycle would pass a legality-only check and is caught here. It sends a request to a bank straight after a write with auto-precharge to that bank. An ACT that comes one cycle too early shows that the internal precharge start or the lockout was computed wrongly, and one that comes late shows the same of the release. A monitor on the bus watches every bank for a precharge that breaks the row-active or write-recovery limit, and for a write to a closed bank. Column starts in the middle of the burst block expose a burst order that does not wrap or that starts from word zero.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CMD,
    S_BURST
  } seq_state_e;
endpackage

// File: rtl/sdw_bank_timer.sv
module sdw_bank_timer #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 5,
  parameter int BL    = 4,
  parameter int TRCD  = 2,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  parameter int TRAS  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             wr_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             wr_ok_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  // counters load N-1 when a command is registered onto the bus; zero means the dependent command may be decided
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(TRCD - 1);
  localparam logic [CNT_W-1:0] LD_RAS = CNT_W'(TRAS - 1);
  localparam logic [CNT_W-1:0] LD_WR  = CNT_W'(BL + TWR - 2);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(TRP - 1);

  logic             open_q, ap_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, ras_q, wrr_q, rp_q;
  logic             ap_fire;

  // internal precharge starts once write recovery and row-active time both ran out
  assign ap_fire = ap_q && (wrr_q == '0) && (ras_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      ap_q   <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      wrr_q  <= '0;
      rp_q   <= '0;
    end else begin
      rcd_q <= act_i ? LD_RCD : ((rcd_q != '0) ? rcd_q - CNT_W'(1) : '0);
      ras_q <= act_i ? LD_RAS : ((ras_q != '0) ? ras_q - CNT_W'(1) : '0);
      wrr_q <= wr_i  ? LD_WR  : ((wrr_q != '0) ? wrr_q - CNT_W'(1) : '0);
      rp_q  <= (pre_i || ap_fire) ? LD_RP : ((rp_q != '0) ? rp_q - CNT_W'(1) : '0);
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end else if (wr_i && ap_i) begin
        open_q <= 1'b0;
        ap_q   <= 1'b1;
      end else if (pre_i) begin
        open_q <= 1'b0;
      end else if (ap_fire) begin
        ap_q <= 1'b0;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign wr_ok_o  = open_q && (rcd_q == '0);
  assign pre_ok_o = open_q && (ras_q == '0) && (wrr_q == '0);
  assign act_ok_o = !open_q && !ap_q && (rp_q == '0);
endmodule

// File: rtl/sdw_burst_unit.sv
module sdw_burst_unit #(
  parameter int DQ_W       = 16,
  parameter int BL         = 4,
  parameter bit INTERLEAVE = 1'b0,
  localparam int BLW       = (BL > 1) ? $clog2(BL) : 1
) (
  input  logic [BL*DQ_W-1:0] data_i,
  input  logic [BLW-1:0]     start_i,
  input  logic [BLW-1:0]     beat_i,
  output logic [DQ_W-1:0]    word_o
);
  generate
    if (BL == 1) begin : g_single
      logic unused_w;
      assign unused_w = ^{start_i, beat_i};
      assign word_o   = data_i[DQ_W-1:0];
    end else begin : g_multi
      logic [BLW-1:0] idx;
      if (INTERLEAVE) begin : g_ilv
        assign idx = start_i ^ beat_i;
      end else begin : g_seq
        assign idx = start_i + beat_i; // wraps inside the aligned block
      end
      assign word_o = data_i[idx*DQ_W +: DQ_W];
    end
  endgenerate
endmodule

// File: rtl/sdw_write_ctrl.sv
module sdw_write_ctrl
  import sdw_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 9,
  parameter int ADDR_W     = 13,
  parameter int AP_BIT     = 10,
  parameter int DQ_W       = 16,
  parameter int BL         = 4,
  parameter bit INTERLEAVE = 1'b0,
  parameter int TRCD       = 2,
  parameter int TWR        = 2,
  parameter int TRP        = 3,
  parameter int TRAS       = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [BA_W-1:0]    req_bank_i,
  input  logic [ROW_W-1:0]   req_row_i,
  input  logic [COL_W-1:0]   req_col_i,
  input  logic               req_ap_i,
  input  logic [BL*DQ_W-1:0] req_data_i,
  output logic [3:0]         cmd_o,
  output logic [BA_W-1:0]    ba_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [DQ_W-1:0]    dq_o,
  output logic               dq_oe_o
);
  localparam int NB    = 1 << BA_W;
  localparam int BLW   = (BL > 1) ? $clog2(BL) : 1;
  localparam int CNT_W = $clog2(TRAS + TRP + BL + TWR + TRCD + 1);
  localparam logic [BLW-1:0] LAST_BEAT = BLW'(BL - 1);

  seq_state_e         state_q;
  logic [BA_W-1:0]    bank_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic               ap_q;
  logic [BL*DQ_W-1:0] data_q;
  logic [BLW-1:0]     beat_q;

  cmd_e               cmd_q, nxt_cmd;
  logic [BA_W-1:0]    ba_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [DQ_W-1:0]    dq_q;
  logic               oe_q;

  logic [NB-1:0]      open_w, wr_ok_w, pre_ok_w, act_ok_w;
  logic [ROW_W-1:0]   row_w [NB];
  logic               act_s, wr_s, pre_s, hit;
  logic [BLW-1:0]     beat_sel;
  logic [DQ_W-1:0]    word_w;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      logic sel;
      assign sel = (bank_q == BA_W'(g));
      sdw_bank_timer #(
        .ROW_W(ROW_W), .CNT_W(CNT_W), .BL(BL),
        .TRCD(TRCD), .TWR(TWR), .TRP(TRP), .TRAS(TRAS)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .act_i   (act_s && sel),
        .wr_i    (wr_s && sel),
        .ap_i    (ap_q),
        .pre_i   (pre_s && sel),
        .row_i   (row_q),
        .open_o  (open_w[g]),
        .row_o   (row_w[g]),
        .wr_ok_o (wr_ok_w[g]),
        .pre_ok_o(pre_ok_w[g]),
        .act_ok_o(act_ok_w[g])
      );
    end
  endgenerate

  assign hit = open_w[bank_q] && (row_w[bank_q] == row_q);

  always_comb begin
    nxt_cmd = CMD_NOP;
    act_s   = 1'b0;
    wr_s    = 1'b0;
    pre_s   = 1'b0;
    if (state_q == S_CMD) begin
      if (hit) begin
        if (wr_ok_w[bank_q]) begin
          nxt_cmd = CMD_WR;
          wr_s    = 1'b1;
        end
      end else if (open_w[bank_q]) begin
        if (pre_ok_w[bank_q]) begin
          nxt_cmd = CMD_PRE;
          pre_s   = 1'b1;
        end
      end else if (act_ok_w[bank_q]) begin
        nxt_cmd = CMD_ACT;
        act_s   = 1'b1;
      end
    end
  end

  assign beat_sel = wr_s ? '0 : beat_q;

  sdw_burst_unit #(.DQ_W(DQ_W), .BL(BL), .INTERLEAVE(INTERLEAVE)) u_burst (
    .data_i (data_q),
    .start_i(BLW'(col_q)),
    .beat_i (beat_sel),
    .word_o (word_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ap_q    <= 1'b0;
      data_q  <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          bank_q  <= req_bank_i;
          row_q   <= req_row_i;
          col_q   <= req_col_i;
          ap_q    <= req_ap_i;
          data_q  <= req_data_i;
          state_q <= S_CMD;
        end
        S_CMD: if (wr_s) begin
          if (BL > 1) begin
            state_q <= S_BURST;
            beat_q  <= BLW'(1);
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_BURST: begin
          if (beat_q == LAST_BEAT) begin
            state_q <= S_IDLE;
          end
          beat_q <= beat_q + BLW'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      cmd_q <= nxt_cmd;
      ba_q  <= bank_q;
      case (nxt_cmd)
        CMD_ACT: addr_q <= ADDR_W'(row_q);
        CMD_WR:  addr_q <= ADDR_W'(col_q) | (ADDR_W'(ap_q) << AP_BIT);
        default: addr_q <= '0;
      endcase
      if (wr_s || state_q == S_BURST) begin
        dq_q <= word_w;
        oe_q <= 1'b1;
      end else begin
        dq_q <= '0;
        oe_q <= 1'b0;
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign cmd_o       = cmd_q;
  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign dq_o        = dq_q;
  assign dq_oe_o     = oe_q;
endmodule

// File: rtl/sdw_write_ctrl_chk.sv
module sdw_write_ctrl_chk
  import sdw_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int BL   = 4,
  parameter int TRCD = 2,
  parameter int TWR  = 2,
  parameter int TRP  = 3,
  parameter int TRAS = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      cmd_o,
  input logic [BA_W-1:0] ba_o,
  input logic            dq_oe_o
);
  localparam int NB = 1 << BA_W;

  assert_write_has_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_WR) |-> dq_oe_o);

  assert_burst_quiet_bus_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && cmd_o != CMD_WR) |-> (cmd_o == CMD_NOP));

  generate
    for (genvar b = 0; b < NB; b++) begin : g_mon
      logic [7:0] since_act_q, since_wr_q;
      logic       is_b;
      assign is_b = (ba_o == BA_W'(b));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          since_act_q <= 8'hFF;
          since_wr_q  <= 8'hFF;
        end else begin
          if (cmd_o == CMD_ACT && is_b) since_act_q <= 8'd1;
          else if (since_act_q != 8'hFF) since_act_q <= since_act_q + 8'd1;
          if (cmd_o == CMD_WR && is_b) since_wr_q <= 8'd1;
          else if (since_wr_q != 8'hFF) since_wr_q <= since_wr_q + 8'd1;
        end
      end

      assert_act_to_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_WR && is_b) |-> (since_act_q >= 8'(TRCD)));

      assert_ras_before_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_PRE && is_b) |-> (since_act_q >= 8'(TRAS)));

      assert_recovery_before_pre_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_PRE && is_b) |-> (since_wr_q >= 8'(BL - 1 + TWR)));

      assert_act_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_ACT && is_b) |-> (since_act_q >= 8'(TRAS + TRP)));
    end
  endgenerate
endmodule

bind sdw_write_ctrl sdw_write_ctrl_chk #(
  .BA_W(BA_W), .BL(BL), .TRCD(TRCD), .TWR(TWR), .TRP(TRP), .TRAS(TRAS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmd_o  (cmd_o),
  .ba_o   (ba_o),
  .dq_oe_o(dq_oe_o)
);

// File: tb/sdw_write_ctrl_tb.sv
`timescale 1ns/1ps
module sdw_write_ctrl_tb;
  import sdw_pkg::*;

  localparam int BL = 4, TRCD = 2, TWR = 2, TRP = 3, TRAS = 6, NV = 12;

  typedef struct packed {
    logic [1:0]  bank;
    logic [12:0] row;
    logic [8:0]  col;
    logic        ap;
    logic [1:0]  kind; // 0 direct write, 1 ACT first, 2 PRE first
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 13'd5,    9'd0,   1'b0, 2'd1},
    '{2'd0, 13'd5,    9'd4,   1'b0, 2'd0},
    '{2'd0, 13'd9,    9'd2,   1'b0, 2'd2},
    '{2'd1, 13'd3,    9'd7,   1'b1, 2'd1},
    '{2'd1, 13'd3,    9'd1,   1'b0, 2'd1},
    '{2'd2, 13'd1,    9'd5,   1'b0, 2'd1},
    '{2'd0, 13'd9,    9'd3,   1'b1, 2'd0},
    '{2'd0, 13'd9,    9'd3,   1'b0, 2'd1},
    '{2'd2, 13'd1,    9'd6,   1'b0, 2'd0},
    '{2'd3, 13'd8191, 9'd511, 1'b0, 2'd1},
    '{2'd3, 13'd0,    9'd0,   1'b1, 2'd2},
    '{2'd2, 13'd2,    9'd1,   1'b1, 2'd2}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_ap = 1'b0, dq_oe;
  logic [1:0]  req_bank = '0, ba;
  logic [12:0] req_row = '0, addr;
  logic [8:0]  req_col = '0;
  logic [63:0] req_data = '0;
  logic [3:0]  cmd;
  logic [15:0] dq;

  int  n_vec = 0, n_bad = 0, cyc = 0;
  bit  done = 1'b0;
  int  act_c [4], wr_c [4], early_act [4];
  bit  open_b [4];
  int  prev_ap_bank = -1, prev_wr = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdw_write_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col), .req_ap_i(req_ap),
    .req_data_i(req_data), .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic logic [15:0] dw(int v, int j);
    return 16'((v + 1) * 16'h0123 + j * 16'h1010);
  endfunction

  // bus legality monitor, one model per bank
  initial for (int b = 0; b < 4; b++) begin
    act_c[b] = -1000; wr_c[b] = -1000; early_act[b] = 0; open_b[b] = 1'b0;
  end

  always @(negedge clk) if (rst_n && !done) begin
    int b;
    b = int'(ba);
    case (cmd)
      CMD_NOP: ;
      CMD_ACT: begin
        chk(!open_b[b], "R7 ACT to open bank", open_b[b], 0);
        chk(cyc >= early_act[b], "R7/R9 ACT spacing", cyc, early_act[b]);
        open_b[b] = 1'b1; act_c[b] = cyc;
      end
      CMD_WR: begin
        chk(open_b[b], "R3 WRITE to closed bank", open_b[b], 1);
        chk(cyc - act_c[b] >= TRCD, "R3 ACT-WRITE spacing", cyc - act_c[b], TRCD);
        wr_c[b] = cyc;
        if (addr[10]) begin
          open_b[b] = 1'b0;
          early_act[b] = ((cyc + BL + TWR - 1) > (act_c[b] + TRAS) ?
                          (cyc + BL + TWR - 1) : (act_c[b] + TRAS)) + TRP;
        end
      end
      CMD_PRE: begin
        chk(open_b[b], "R6 PRE to closed bank", open_b[b], 1);
        chk(cyc - act_c[b] >= TRAS, "R6 tRAS", cyc - act_c[b], TRAS);
        chk(cyc >= wr_c[b] + BL - 1 + TWR, "R6 tWR", cyc, wr_c[b] + BL - 1 + TWR);
        open_b[b] = 1'b0; early_act[b] = cyc + TRP;
      end
      default: chk(1'b0, "R2 command code", cmd, CMD_NOP);
    endcase
  end

  task automatic run_vec(input int v);
    vec_t t;
    int   first, act_t, pre_t, wr_t, guard, start, idx;
    bit   got_act, got_pre;
    t = VECS[v];
    first = -1; got_act = 0; got_pre = 0; act_t = 0; pre_t = 0; guard = 0;
    @(negedge clk);
    req_bank = t.bank; req_row = t.row; req_col = t.col; req_ap = t.ap;
    for (int j = 0; j < BL; j++) req_data[j*16 +: 16] = dw(v, j);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (cmd != CMD_WR && guard < 100) begin
      if (cmd == CMD_ACT) begin
        got_act = 1; act_t = cyc; if (first < 0) first = 1;
        chk(addr == t.row && ba == t.bank, "R2 ACT row/bank", addr, t.row);
      end else if (cmd == CMD_PRE) begin
        got_pre = 1; pre_t = cyc; if (first < 0) first = 2;
        chk(addr[10] == 1'b0 && ba == t.bank, "R2 PRE single bank", addr[10], 0);
      end
      guard++;
      @(negedge clk);
    end
    if (first < 0) first = 0;
    wr_t = cyc;
    chk(first == int'(t.kind), "R8 command sequence", first, t.kind);
    chk(addr[8:0] == t.col && addr[10] == t.ap && ba == t.bank, "R2 WRITE fields",
        {ba, addr}, {t.bank, 2'b0, t.ap, 1'b0, t.col});
    if (got_act) chk(wr_t - act_t == TRCD, "R3 exact ACT-WRITE", wr_t - act_t, TRCD);
    if (got_act && got_pre) chk(act_t - pre_t == TRP, "R7 exact PRE-ACT", act_t - pre_t, TRP);
    if (got_act && prev_ap_bank == int'(t.bank))
      chk(act_t - prev_wr == BL + TWR - 1 + TRP, "R9 auto-precharge release",
          act_t - prev_wr, BL + TWR - 1 + TRP);
    start = int'(t.col) % BL;
    for (int i = 0; i < BL; i++) begin
      if (i > 0) @(negedge clk);
      idx = (start + i) % BL;
      chk(dq_oe == 1'b1, "R4 data enable in burst", dq_oe, 1);
      chk(dq == dw(v, idx), "R5 burst word order", dq, dw(v, idx));
      if (i == 0 && BL > 1) chk(!req_ready, "R10 ready low in burst", req_ready, 0);
      if (i > 0) chk(cmd == CMD_NOP, "R11 NOP during burst", cmd, CMD_NOP);
    end
    @(negedge clk);
    chk(!dq_oe, "R4 burst length", dq_oe, 0);
    prev_ap_bank = t.ap ? int'(t.bank) : -1;
    prev_wr = wr_t;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && cmd == CMD_NOP && !dq_oe, "R1 state in reset", {req_ready, cmd, dq_oe}, 6'b101110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && cmd == CMD_NOP && !dq_oe, "R1 state after reset", {req_ready, cmd, dq_oe}, 6'b101110);
    for (int v = 0; v < NV; v++) run_vec(v);
    // idle bus with no request
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(cmd == CMD_NOP && !dq_oe, "R11 idle NOP", cmd, CMD_NOP);
    end
    chk(req_ready, "R10 ready when idle", req_ready, 1);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", cyc, 0);
      report();
    end
  end
endmodule